// File: doc/BRIEF.md
# Smart-Card Half-Duplex Serial Transceiver

This block moves bytes across the single bidirectional data wire of a subscriber-identity card link. One open-drain output can only pull the wire low; the same wire is read back through an input. A write to the transmit data port sends one frame: a start bit, eight data bits, a parity bit and a stop bit. A falling edge on the wire that is still low at mid-bit starts a reception. The receiver then decodes eight data bits and a parity bit. It can pull the wire low for one bit time during the guard period to tell the card that the parity was wrong.

A single convention input picks how the eight data bits sit on the wire. In the direct convention the bits go out least significant first, without inversion, under even parity. In the inverse convention they go out most significant first, inverted, under odd parity. The transmitter and the receiver share one oversampling tick generator. It divides a selected source clock by 16×(m+1) and restarts at the start of every frame, so that each bit lasts a fixed whole number of cycles. Completion of a transmission and of a reception are each signalled by a one-cycle pulse.

Top module: `sc_uart`

## Requirements
- R1: One bit lasts 16×(m+1)×S clock cycles, where m is `div_m` and S is set by `clk_src`. Code 0 (and 3) gives S=1, code 1 gives S=8, and code 2 gives S=1 when `pre_n` is 0 and S=2×`pre_n` otherwise.
- R2: An accepted write drives the frame in the cycle after the accepting edge. The frame is a low start bit, eight data bits, a parity bit and a high stop bit, each one bit time long.
- R3: With `inverse`=0, data bit 0 is sent first, bits are not inverted, and the parity bit makes the count of high levels among the nine data-and-parity bits on the wire even.
- R4: With `inverse`=1, data bit 7 is sent first, every data bit is inverted, and the parity bit makes the count of high levels among the nine data-and-parity bits on the wire odd.
- R5: `line_pull` is high only while a low level is to be driven. After reset it is low, and `tx_done`, `rx_done`, `rx_perr` are low and `rx_data` is 0.
- R6: `tx_done` is a one-cycle pulse, seen exactly 11 bit times after the accepting edge. A write while a frame is being sent is ignored and does not change the frame.
- R7: A low on the wire that has returned high by mid-bit of the start bit is ignored and produces no `rx_done`.
- R8: A received frame yields a one-cycle `rx_done` at the stop-bit sample point. `rx_data` then holds the byte decoded with the convention of R3 or R4.
- R9: `rx_perr` pulses together with `rx_done` when the parity does not match the convention. When `err_sig_en` is 1, the block then pulls the wire low from half a bit after the stop-bit sample for one bit time. When `err_sig_en` is 0, it does not pull the wire.
- R10: With `tx_en`=0 a write is ignored, the wire stays released and no `tx_done` appears. With `rx_en`=0 a frame on the wire produces no `rx_done` and leaves `rx_data` unchanged.
- R11: The receiver ignores the wire while the transmitter is sending, so the block's own frame never produces `rx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_src | input | 2 | Tick source: 0 undivided, 1 divide by 8, 2 prescaled, 3 undivided |
| pre_n | input | 4 | Prescaler: 0 no division, else divide by 2×pre_n |
| div_m | input | 8 | Divider value m |
| inverse | input | 1 | 0 direct convention, 1 inverse convention |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| err_sig_en | input | 1 | Enable error signal on bad received parity |
| tx_wr | input | 1 | Write strobe for tx_data, starts a frame |
| tx_data | input | 8 | Byte to send |
| tx_done | output | 1 | One-cycle pulse at end of the stop bit |
| rx_data | output | 8 | Last received byte |
| rx_done | output | 1 | One-cycle pulse at reception completion |
| rx_perr | output | 1 | Parity error, pulses with rx_done |
| line_in | input | 1 | Level read back from the data wire |
| line_pull | output | 1 | 1 pulls the open-drain wire low |

## Verification
A slip in the bit or sub-bit counters shows up as a wrong `tx_done` cycle count and as wrongly placed wire levels. This appears within the first frame, at most one bit time after the slip. A wrong bit order, inversion or parity term shows as a mismatched wire pattern or `rx_data` at the end of the frame in which it occurs. A receiver state stuck in the error or guard phase shows as an extra low pulse on the wire, or as a missing `rx_done` on the next frame. The bench sweeps bytes under both conventions, divider settings under every source selection, good and bad parity with the error signal on and off, and the disabled and glitch cases. It compares every wire level and pulse time with values it works out arithmetically.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 3;
    localparam int OVS        = 16;
    localparam int OVS_W      = $clog2(OVS);
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        SRC_UNDIV = 2'd0,
        SRC_DIV8  = 2'd1,
        SRC_PRESC = 2'd2,
        SRC_SPARE = 2'd3
    } clk_src_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP,
        RX_GUARD,
        RX_ERR
    } rx_state_e;

    // Map a byte to wire order and levels, or back; the mapping is its own inverse.
    function automatic logic [DATA_W-1:0] conv_map(input logic [DATA_W-1:0] v, input logic inv);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = inv ? ~v[DATA_W-1-i] : v[i];
        end
        return r;
    endfunction

    // Parity level for wire bits: even total in direct, odd total in inverse.
    function automatic logic par_of(input logic [DATA_W-1:0] wire_bits, input logic inv);
        return (^wire_bits) ^ inv;
    endfunction
endpackage

// File: rtl/sc_uart_baud.sv
module sc_uart_baud
    import sc_uart_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PRE_W = 4,
    parameter int DIV8  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  clk_src_e         src_sel,
    input  logic [PRE_W-1:0] pre_n,
    input  logic [DIV_W-1:0] div_m,
    output logic             tick
);
    localparam int PCNT_W = PRE_W + 1;
    localparam int D8_W   = $clog2(DIV8);

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] pre_lim;
    logic [D8_W-1:0]   c8;
    logic [DIV_W-1:0]  dcnt;
    logic              pre_hit;
    logic              src_en;

    assign pre_lim = {pre_n, 1'b0} - PCNT_W'(1);
    assign pre_hit = (pre_n == '0) || (pcnt == pre_lim);

    always_comb begin
        case (src_sel)
            SRC_DIV8:  src_en = (c8 == D8_W'(DIV8 - 1));
            SRC_PRESC: src_en = pre_hit;
            default:   src_en = 1'b1;
        endcase
    end

    assign tick = src_en && (dcnt == div_m) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt <= '0;
            c8   <= '0;
            dcnt <= '0;
        end else begin
            c8   <= (c8 == D8_W'(DIV8 - 1)) ? '0 : c8 + D8_W'(1);
            pcnt <= pre_hit ? '0 : pcnt + PCNT_W'(1);
            if (src_en) begin
                dcnt <= (dcnt == div_m) ? '0 : dcnt + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx
    import sc_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              inv,
    input  logic              en,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    input  logic              rx_idle,
    output logic              start,
    output logic              busy,
    output logic              pull,
    output logic              done
);
    logic [FRAME_BITS-1:0] shreg;
    logic [OVS_W-1:0]      sub;
    logic [IDX_W-1:0]      idx;
    logic [DATA_W-1:0]     wbits;

    assign wbits = conv_map(data, inv);
    assign start = wr && en && !busy && rx_idle;
    assign pull  = busy && !shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            shreg <= '1;
            sub   <= '0;
            idx   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                shreg <= {1'b1, par_of(wbits, inv), wbits, 1'b0};
                sub   <= '0;
                idx   <= '0;
            end else if (busy && tick) begin
                if (sub == OVS_W'(OVS - 1)) begin
                    sub <= '0;
                    if (idx == IDX_W'(FRAME_BITS - 1)) begin
                        busy  <= 1'b0;
                        done  <= 1'b1;
                        shreg <= '1;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                    end
                end else begin
                    sub <= sub + OVS_W'(1);
                end
            end
        end
    end

    // R2
    tx_start_low_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> pull);
    // R6
    tx_done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R6
    tx_done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
endmodule

// File: rtl/sc_uart_rx.sv
module sc_uart_rx
    import sc_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              inv,
    input  logic              en,
    input  logic              err_en,
    input  logic              line_in,
    input  logic              tx_busy,
    input  logic              tx_start,
    output logic              start,
    output logic              idle,
    output logic [DATA_W-1:0] data,
    output logic              done,
    output logic              perr,
    output logic              err_pull
);
    rx_state_e        state;
    logic [1:0]       sync;
    logic             rxs;
    logic             rxs_q;
    logic [OVS_W-1:0] sub;
    logic [IDX_W-1:0] idx;
    logic [DATA_W:0]  shreg;
    logic             mid;
    logic             last;
    logic             bad;

    assign rxs      = sync[1];
    assign idle     = (state == RX_IDLE);
    assign err_pull = (state == RX_ERR);
    assign start    = idle && en && !tx_busy && !tx_start && !rxs && rxs_q;
    assign mid      = tick && (sub == OVS_W'(OVS / 2 - 1));
    assign last     = tick && (sub == OVS_W'(OVS - 1));
    assign bad      = shreg[DATA_W] != par_of(shreg[DATA_W-1:0], inv);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= '1;
            rxs_q <= 1'b1;
        end else begin
            sync  <= {sync[0], line_in};
            rxs_q <= rxs;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            sub   <= '0;
            idx   <= '0;
            shreg <= '0;
            data  <= '0;
            done  <= 1'b0;
            perr  <= 1'b0;
        end else begin
            done <= 1'b0;
            perr <= 1'b0;
            if (state != RX_IDLE && tick) begin
                sub <= sub + OVS_W'(1);
            end
            case (state)
                RX_IDLE: begin
                    if (start) begin
                        state <= RX_START;
                        sub   <= '0;
                    end
                end
                RX_START: begin
                    if (mid && rxs) begin
                        state <= RX_IDLE;
                    end else if (last) begin
                        state <= RX_BITS;
                        idx   <= '0;
                    end
                end
                RX_BITS: begin
                    if (mid) begin
                        shreg <= {rxs, shreg[DATA_W:1]};
                    end
                    if (last) begin
                        if (idx == IDX_W'(DATA_W)) begin
                            state <= RX_STOP;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                RX_STOP: begin
                    if (mid) begin
                        done  <= 1'b1;
                        perr  <= bad;
                        data  <= conv_map(shreg[DATA_W-1:0], inv);
                        state <= (bad && err_en) ? RX_GUARD : RX_IDLE;
                    end
                end
                RX_GUARD: begin
                    if (last) begin
                        state <= RX_ERR;
                    end
                end
                RX_ERR: begin
                    if (last) begin
                        state <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R9
    rx_perr_with_done_chk: assert property (@(posedge clk) disable iff (rst) perr |-> done);
    // R11
    half_duplex_chk: assert property (@(posedge clk) disable iff (rst) tx_busy |-> idle);
    // R9
    good_parity_no_err_chk: assert property (@(posedge clk) disable iff (rst) (done && !perr) |-> idle);
endmodule

// File: rtl/sc_uart.sv
module sc_uart
    import sc_uart_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PRE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        clk_src,
    input  logic [PRE_W-1:0]  pre_n,
    input  logic [DIV_W-1:0]  div_m,
    input  logic              inverse,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              err_sig_en,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_done,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done,
    output logic              rx_perr,
    input  logic              line_in,
    output logic              line_pull
);
    logic tick;
    logic tx_start;
    logic rx_start;
    logic tx_busy;
    logic tx_pull;
    logic rx_idle;
    logic err_pull;

    sc_uart_baud #(.DIV_W(DIV_W), .PRE_W(PRE_W), .DIV8(8)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .restart (tx_start || rx_start),
        .src_sel (clk_src_e'(clk_src)),
        .pre_n   (pre_n),
        .div_m   (div_m),
        .tick    (tick)
    );

    sc_uart_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .inv     (inverse),
        .en      (tx_en),
        .wr      (tx_wr),
        .data    (tx_data),
        .rx_idle (rx_idle),
        .start   (tx_start),
        .busy    (tx_busy),
        .pull    (tx_pull),
        .done    (tx_done)
    );

    sc_uart_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .inv      (inverse),
        .en       (rx_en),
        .err_en   (err_sig_en),
        .line_in  (line_in),
        .tx_busy  (tx_busy),
        .tx_start (tx_start),
        .start    (rx_start),
        .idle     (rx_idle),
        .data     (rx_data),
        .done     (rx_done),
        .perr     (rx_perr),
        .err_pull (err_pull)
    );

    assign line_pull = tx_pull || err_pull;

    // R5
    pull_source_chk: assert property (@(posedge clk) disable iff (rst) !(tx_pull && err_pull));
endmodule

// File: tb/sc_uart_bench.sv
module sc_uart_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] clk_src = 2'd0;
    logic [3:0] pre_n = 4'd0;
    logic [7:0] div_m = 8'd0;
    logic       inverse = 1'b0;
    logic       tx_en = 1'b1;
    logic       rx_en = 1'b1;
    logic       err_sig_en = 1'b1;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       tx_done;
    logic [7:0] rx_data;
    logic       rx_done;
    logic       rx_perr;
    logic       line_pull;
    logic       card_pull = 1'b0;
    logic       line;

    int compared = 0;
    int mismatched = 0;

    assign line = !(line_pull || card_pull);

    always #2 clk = ~clk;

    sc_uart u_sc_uart (
        .clk(clk), .rst(rst), .clk_src(clk_src), .pre_n(pre_n), .div_m(div_m),
        .inverse(inverse), .tx_en(tx_en), .rx_en(rx_en), .err_sig_en(err_sig_en),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_done(tx_done), .rx_data(rx_data),
        .rx_done(rx_done), .rx_perr(rx_perr), .line_in(line), .line_pull(line_pull)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic inv);
        logic [7:0] w;
        for (int i = 0; i < 8; i++) w[i] = inv ? ~d[7-i] : d[i];
        return {1'b1, (^w) ^ inv, w, 1'b0};
    endfunction

    function automatic int bit_cycles(input logic [1:0] s, input logic [3:0] n, input logic [7:0] m);
        int sdiv;
        sdiv = (s == 2'd1) ? 8 : (s == 2'd2 && n != 0) ? 2 * n : 1;
        return 16 * (m + 1) * sdiv;
    endfunction

    // Sends one byte; returns wire levels sampled at mid-bit and the tx_done cycle.
    task automatic tx_frame(input logic [7:0] d, input bit extra_wr,
                            output logic [10:0] seen, output int done_cyc, output bit saw_rx);
        int b;
        b = bit_cycles(clk_src, pre_n, div_m);
        seen = '0;
        done_cyc = 0;
        saw_rx = 1'b0;
        @(negedge clk);
        tx_data = d;
        tx_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_wr = 1'b0;
        for (int cyc = 1; cyc <= 11 * b + 4; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            tx_wr = 1'b0;
            if (extra_wr && cyc == b + 3) begin
                tx_data = ~d;
                tx_wr = 1'b1;
            end
            if (cyc % b == b / 2 && cyc / b < 11) seen[cyc / b] = line;
            if (tx_done && done_cyc == 0) done_cyc = cyc;
            if (rx_done) saw_rx = 1'b1;
        end
        tx_wr = 1'b0;
    endtask

    // Card sends a frame at 16 cycles per bit; records results and wire levels.
    task automatic rx_frame(input logic [10:0] fr, input int low_len,
                            output bit got, output logic [7:0] got_d, output bit got_p,
                            output logic l_err, output logic l_after);
        got = 1'b0;
        got_d = '0;
        got_p = 1'b0;
        l_err = 1'b1;
        l_after = 1'b1;
        for (int t = 0; t < 220; t++) begin
            @(negedge clk);
            if (low_len > 0) card_pull = (t < low_len);
            else card_pull = (t < 176) ? !fr[t / 16] : 1'b0;
            @(posedge clk);
            #1;
            if (rx_done) begin
                got = 1'b1;
                got_d = rx_data;
                got_p = rx_perr;
            end
            if (t == 186) l_err = line;
            if (t == 200) l_after = line;
        end
        card_pull = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [10:0] seen;
        int dc;
        bit srx;
        bit got;
        logic [7:0] gd;
        bit gp;
        logic le;
        logic la;
        logic [7:0] prev;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5 reset state
        check(!line_pull && !tx_done && !rx_done && !rx_perr && rx_data == 0, "R5 reset",
              {line_pull, tx_done, rx_done, rx_perr, rx_data}, 0);

        // R2 R3 R4 R6 R11: byte sweep in both conventions
        for (int cv = 0; cv < 2; cv++) begin
            inverse = cv[0];
            for (int v = 0; v < 256; v += 17) begin
                tx_frame(v[7:0], v == 34, seen, dc, srx);
                check(seen == exp_frame(v[7:0], cv[0]), cv ? "R4 inverse tx frame" : "R3 direct tx frame (R2)",
                      seen, exp_frame(v[7:0], cv[0]));
                check(dc == 176, "R6 tx_done cycle", dc, 176);
                check(!srx, "R11 own frame not received", srx, 0);
                check(line == 1'b1 && !line_pull, "R5 released after frame", line_pull, 0);
            end
        end

        // R1 rate sweep across source selections
        inverse = 1'b0;
        for (int k = 0; k < 7; k++) begin
            case (k)
                0: begin clk_src = 2'd0; pre_n = 4'd0; div_m = 8'd3; end
                1: begin clk_src = 2'd1; pre_n = 4'd0; div_m = 8'd0; end
                2: begin clk_src = 2'd2; pre_n = 4'd0; div_m = 8'd1; end
                3: begin clk_src = 2'd2; pre_n = 4'd3; div_m = 8'd0; end
                4: begin clk_src = 2'd2; pre_n = 4'd1; div_m = 8'd2; end
                5: begin clk_src = 2'd3; pre_n = 4'd5; div_m = 8'd1; end
                default: begin clk_src = 2'd1; pre_n = 4'd0; div_m = 8'd1; end
            endcase
            tx_frame(8'hA5, 1'b0, seen, dc, srx);
            check(dc == 11 * bit_cycles(clk_src, pre_n, div_m), "R1 bit period", dc,
                  11 * bit_cycles(clk_src, pre_n, div_m));
            check(seen == exp_frame(8'hA5, 1'b0), "R1 frame at rate", seen, exp_frame(8'hA5, 1'b0));
        end
        clk_src = 2'd0;
        pre_n = 4'd0;
        div_m = 8'd0;

        // R8 R9 receive sweep: conventions, good and bad parity, error signal on and off
        for (int cv = 0; cv < 2; cv++) begin
            inverse = cv[0];
            for (int v = 3; v < 256; v += 23) begin
                for (int bp = 0; bp < 2; bp++) begin
                    err_sig_en = (v % 2 == 1);
                    rx_frame(exp_frame(v[7:0], cv[0]) ^ (bp ? 11'h200 : 11'h000), 0, got, gd, gp, le, la);
                    check(got && gd == v[7:0], "R8 rx data", gd, v);
                    check(gp == bp[0], "R9 rx_perr", gp, bp);
                    check(le == !(bp[0] && err_sig_en), "R9 error signal level", le, !(bp[0] && err_sig_en));
                    check(la == 1'b1, "R9 error signal released", la, 1);
                end
            end
        end
        err_sig_en = 1'b1;

        // R7 short start glitch
        rx_frame('1, 4, got, gd, gp, le, la);
        check(!got, "R7 glitch ignored", got, 0);

        // R10 receive disabled
        prev = rx_data;
        rx_en = 1'b0;
        rx_frame(exp_frame(8'h3C, inverse), 0, got, gd, gp, le, la);
        check(!got && rx_data == prev, "R10 rx disabled", rx_data, prev);
        rx_en = 1'b1;

        // R10 transmit disabled
        tx_en = 1'b0;
        begin
            bit low_seen;
            bit done_seen;
            low_seen = 1'b0;
            done_seen = 1'b0;
            @(negedge clk);
            tx_data = 8'h00;
            tx_wr = 1'b1;
            @(negedge clk);
            tx_wr = 1'b0;
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                if (!line) low_seen = 1'b1;
                if (tx_done) done_seen = 1'b1;
            end
            check(!low_seen && !done_seen, "R10 tx disabled", {low_seen, done_seen}, 0);
        end
        tx_en = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule